// File: doc/BRIEF.md
# Rolling DRAM Row Refresh Scheduler

This block produces the refresh work for a DRAM device whose banks are arranged in groups. Within one bank, refresh means sweeping every row in turn. Each row step is a fixed-length sequence: shut every row, precharge the bitlines, open the target row, and let the sense stage rewrite it. A bank's sweep must end well inside the retention window, and a new sweep of all banks begins at every window boundary.

Refresh is staggered, so a group never has more than one bank refreshing. The other banks of that group stay open to normal traffic, and the groups run side by side. The block asks the access scheduler for a bank through a per-bank request. It starts that bank's sweep only when the access scheduler returns an acknowledge. While the sweep runs, the bank's busy flag is high, and the access scheduler must not send reads or writes to that bank until the flag clears.

The retention timer runs freely and never waits for acknowledges. A boundary that falls while a group is still sweeping is remembered, and it starts the next sweep as soon as the current one ends. The row count per bank, the cycles per row, the window length and the bank organisation are all parameters, so a small configuration can stand in for the full one.

Top module: `rfsh_scheduler`

## Requirements
- R1: While reset is held, and on the first cycle after it, every bank_busy, refresh_req and pass_done bit is 0 and every row counter is 0.
- R2: Within one group, requests go out one bank at a time. They run in ascending local bank index, from 0 up to BANKS_PER_GROUP-1, and each bank in the group is refreshed once per sweep. At most one refresh_req bit of a group is high, and a bank that is busy is never requesting.
- R3: A bank starts refreshing only on a clock edge where its refresh_req and refresh_ack are both high. At that edge bank_busy rises. An acknowledge on a bank that is not requesting has no effect.
- R4: No group ever has more than one busy bank at a time. Different groups may refresh banks at the same time.
- R5: A busy bank holds each row for ROW_CYCLES cycles, and its row counter steps up by one at each row boundary. bank_busy stays high for exactly ROWS*ROW_CYCLES cycles.
- R6: After the last row (ROWS-1), the row counter wraps to 0 and bank_busy falls at the same edge, and pass_done for that bank is high for exactly that one cycle.
- R7: The cycle after a bank's pass_done pulse, the group raises refresh_req for its next bank. After the group's last bank, it raises the request for bank 0 only if a new sweep is due.
- R8: A free-running counter marks a window boundary every PERIOD_CYCLES cycles, whatever the acknowledges do. An idle group raises refresh_req for its bank 0 on the cycle after a boundary. If a boundary falls while the group is mid-sweep, the group holds it and starts the next sweep right after the current one. The first sweep starts one cycle after reset is released.
- R9: A bank's row counter does not change while that bank is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_ack | input | GROUPS*BANKS_PER_GROUP | Per-bank acknowledge from the access scheduler; bank b = group*BANKS_PER_GROUP + local index |
| refresh_req | output | GROUPS*BANKS_PER_GROUP | Per-bank refresh request |
| bank_busy | output | GROUPS*BANKS_PER_GROUP | Per-bank refresh-in-progress flag |
| row_count | output | GROUPS*BANKS_PER_GROUP*ROW_W | Per-bank row counter; bank b occupies bits [b*ROW_W +: ROW_W] |
| pass_done | output | GROUPS*BANKS_PER_GROUP | One-cycle pulse when a bank's sweep wraps |

## Verification
The bench drives the acknowledge in four ways, each aimed at a different behaviour. Echoing each request at once sets the row timing and the order of banks in a group. Per-bank delays of varying length separate a refresh that starts on the acknowledge from one that starts on the request alone. Holding the acknowledge high on every bank shows whether stray acknowledges to banks that are not requesting get ignored. A long stall with the acknowledge held low lets several window boundaries pass while requests wait, which exercises the held-boundary path and the rule that the timer never pauses.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Group sequencer states
    typedef enum logic [1:0] {
        GRP_IDLE = 2'd0,   // waiting for a window boundary
        GRP_ASK  = 2'd1,   // requesting the bank at the current index
        GRP_RUN  = 2'd2    // that bank is sweeping its rows
    } grp_state_e;

endpackage

// File: rtl/rfsh_period_timer.sv
module rfsh_period_timer #(
    parameter int PERIOD_CYCLES = 51200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_tick
);
    localparam int PW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [PW-1:0] LAST_CNT = PW'(PERIOD_CYCLES - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        period_tick = (tmr_q.cnt == LAST_CNT);
        if (period_tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/rfsh_bank_engine.sv
module rfsh_bank_engine #(
    parameter int ROWS       = 65536,
    parameter int ROW_CYCLES = 40
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    output logic                                   busy,
    output logic                                   done,
    output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int TW = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [TW-1:0] LAST_CYC = TW'(ROW_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [RW-1:0] row;
        logic [TW-1:0] cyc;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (eng_q.busy) begin
            if (eng_q.cyc == LAST_CYC) begin
                eng_d.cyc = '0;
                if (eng_q.row == LAST_ROW) begin
                    eng_d.row  = '0;
                    eng_d.busy = 1'b0;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.row = eng_q.row + 1'b1;
                end
            end else begin
                eng_d.cyc = eng_q.cyc + 1'b1;
            end
        end else if (start) begin
            eng_d.busy = 1'b1;
            eng_d.cyc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy = eng_q.busy;
    assign done = eng_q.done;
    assign row  = eng_q.row;

endmodule

// File: rtl/rfsh_group_ctrl.sv
module rfsh_group_ctrl
    import rfsh_pkg::*;
#(
    parameter int BANKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_tick,
    input  logic [BANKS-1:0] ack,
    input  logic [BANKS-1:0] bank_done,
    output logic [BANKS-1:0] req,
    output logic [BANKS-1:0] start
);
    localparam int IW = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(BANKS - 1);

    typedef struct packed {
        grp_state_e    st;
        logic [IW-1:0] idx;
        logic          pend;
    } grp_t;

    grp_t grp_d, grp_q;
    logic done_sel;

    always_comb begin
        done_sel = 1'b0;
        for (int k = 0; k < BANKS; k++) begin
            req[k]   = (grp_q.st == GRP_ASK) && (grp_q.idx == IW'(k));
            start[k] = req[k] && ack[k];
            if (grp_q.idx == IW'(k)) begin
                done_sel = bank_done[k];
            end
        end

        grp_d      = grp_q;
        grp_d.pend = grp_q.pend | period_tick;
        unique case (grp_q.st)
            GRP_IDLE: begin
                if (grp_q.pend || period_tick) begin
                    grp_d.st   = GRP_ASK;
                    grp_d.idx  = '0;
                    grp_d.pend = 1'b0;
                end
            end
            GRP_ASK: begin
                if (|start) begin
                    grp_d.st = GRP_RUN;
                end
            end
            GRP_RUN: begin
                if (done_sel) begin
                    if (grp_q.idx == LAST_IDX) begin
                        grp_d.idx  = '0;
                        grp_d.pend = 1'b0;
                        grp_d.st   = (grp_q.pend || period_tick) ? GRP_ASK : GRP_IDLE;
                    end else begin
                        grp_d.idx = grp_q.idx + 1'b1;
                        grp_d.st  = GRP_ASK;
                    end
                end
            end
            default: begin
                grp_d.st = GRP_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q.st   <= GRP_IDLE;
            grp_q.idx  <= '0;
            grp_q.pend <= 1'b1;
        end else begin
            grp_q <= grp_d;
        end
    end

endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler #(
    parameter int GROUPS          = 8,
    parameter int BANKS_PER_GROUP = 4,
    parameter int ROWS            = 65536,
    parameter int ROW_CYCLES      = 40,
    parameter int PERIOD_CYCLES   = 51200000
) (
    input  logic                                                        clk,
    input  logic                                                        rst_n,
    input  logic [GROUPS*BANKS_PER_GROUP-1:0]                           refresh_ack,
    output logic [GROUPS*BANKS_PER_GROUP-1:0]                           refresh_req,
    output logic [GROUPS*BANKS_PER_GROUP-1:0]                           bank_busy,
    output logic [GROUPS*BANKS_PER_GROUP*((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row_count,
    output logic [GROUPS*BANKS_PER_GROUP-1:0]                           pass_done
);
    localparam int NB    = GROUPS * BANKS_PER_GROUP;
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic          period_tick;
    logic [NB-1:0] bank_start;

    rfsh_period_timer #(
        .PERIOD_CYCLES(PERIOD_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_tick(period_tick)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        rfsh_group_ctrl #(
            .BANKS(BANKS_PER_GROUP)
        ) u_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .period_tick(period_tick),
            .ack        (refresh_ack[g*BANKS_PER_GROUP +: BANKS_PER_GROUP]),
            .bank_done  (pass_done[g*BANKS_PER_GROUP +: BANKS_PER_GROUP]),
            .req        (refresh_req[g*BANKS_PER_GROUP +: BANKS_PER_GROUP]),
            .start      (bank_start[g*BANKS_PER_GROUP +: BANKS_PER_GROUP])
        );
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        rfsh_bank_engine #(
            .ROWS      (ROWS),
            .ROW_CYCLES(ROW_CYCLES)
        ) u_engine (
            .clk  (clk),
            .rst_n(rst_n),
            .start(bank_start[b]),
            .busy (bank_busy[b]),
            .done (pass_done[b]),
            .row  (row_count[b*ROW_W +: ROW_W])
        );
    end

endmodule

// File: rtl/rfsh_scheduler_chk.sv
module rfsh_scheduler_chk #(
    parameter int GROUPS = 8,
    parameter int BPG    = 4,
    parameter int ROW_W  = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [GROUPS*BPG-1:0]       refresh_ack,
    input logic [GROUPS*BPG-1:0]       refresh_req,
    input logic [GROUPS*BPG-1:0]       bank_busy,
    input logic [GROUPS*BPG*ROW_W-1:0] row_count,
    input logic [GROUPS*BPG-1:0]       pass_done
);
    localparam int NB = GROUPS * BPG;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assert_one_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(bank_busy[g*BPG +: BPG]) <= 1);
        assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(refresh_req[g*BPG +: BPG]));
    end

    for (genvar b = 0; b < NB; b++) begin : g_bk
        assert_start_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bank_busy[b]) |-> $past(refresh_req[b] && refresh_ack[b]));
        assert_no_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            bank_busy[b] |-> !refresh_req[b]);
        assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pass_done[b] |=> !pass_done[b]);
        assert_done_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pass_done[b] |-> (!bank_busy[b] && (row_count[b*ROW_W +: ROW_W] == '0)
                              && $past(bank_busy[b])));
        assert_row_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_busy[b] |=> $stable(row_count[b*ROW_W +: ROW_W]));
        assert_row_moves_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(row_count[b*ROW_W +: ROW_W]) |-> $past(bank_busy[b]));
    end

endmodule

bind rfsh_scheduler rfsh_scheduler_chk #(
    .GROUPS(GROUPS),
    .BPG   (BANKS_PER_GROUP),
    .ROW_W (ROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh_ack(refresh_ack),
    .refresh_req(refresh_req),
    .bank_busy  (bank_busy),
    .row_count  (row_count),
    .pass_done  (pass_done)
);

// File: tb/tb_rfsh_scheduler.sv
module tb_rfsh_scheduler;
    localparam int G      = 2;
    localparam int BPG    = 3;
    localparam int ROWS   = 4;
    localparam int RC     = 3;
    localparam int PERIOD = 60;
    localparam int NB     = G * BPG;
    localparam int RW     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NB-1:0]    refresh_ack = '0;
    logic [NB-1:0]    refresh_req;
    logic [NB-1:0]    bank_busy;
    logic [NB*RW-1:0] row_count;
    logic [NB-1:0]    pass_done;

    int checks = 0;
    int errors = 0;
    int mode   = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    rfsh_scheduler #(
        .GROUPS         (G),
        .BANKS_PER_GROUP(BPG),
        .ROWS           (ROWS),
        .ROW_CYCLES     (RC),
        .PERIOD_CYCLES  (PERIOD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .refresh_ack(refresh_ack),
        .refresh_req(refresh_req),
        .bank_busy  (bank_busy),
        .row_count  (row_count),
        .pass_done  (pass_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: group state 0 idle, 1 asking, 2 running
    int m_cnt;
    int m_st[G];
    int m_idx[G];
    int m_pend[G];
    int m_busy[NB];
    int m_row[NB];
    int m_cyc[NB];
    int m_done[NB];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            for (int g = 0; g < G; g++) begin
                m_st[g] = 0; m_idx[g] = 0; m_pend[g] = 1;
            end
            for (int b = 0; b < NB; b++) begin
                m_busy[b] = 0; m_row[b] = 0; m_cyc[b] = 0; m_done[b] = 0;
            end
        end else begin
            int tick;
            int st_b[NB];
            tick = (m_cnt == PERIOD - 1);
            for (int b = 0; b < NB; b++)
                st_b[b] = (m_st[b / BPG] == 1 && m_idx[b / BPG] == b % BPG && refresh_ack[b]) ? 1 : 0;
            for (int g = 0; g < G; g++) begin
                int dsel;
                int anyst;
                dsel = m_done[g * BPG + m_idx[g]];
                anyst = 0;
                for (int k = 0; k < BPG; k++) anyst |= st_b[g * BPG + k];
                if (m_st[g] == 0) begin
                    if (m_pend[g] || tick) begin m_st[g] = 1; m_idx[g] = 0; m_pend[g] = 0; end
                end else if (m_st[g] == 1) begin
                    if (tick) m_pend[g] = 1;
                    if (anyst) m_st[g] = 2;
                end else begin
                    if (tick) m_pend[g] = 1;
                    if (dsel) begin
                        if (m_idx[g] == BPG - 1) begin
                            m_st[g] = m_pend[g] ? 1 : 0;
                            m_idx[g] = 0; m_pend[g] = 0;
                        end else begin
                            m_idx[g]++; m_st[g] = 1;
                        end
                    end
                end
            end
            for (int b = 0; b < NB; b++) begin
                m_done[b] = 0;
                if (m_busy[b]) begin
                    if (m_cyc[b] == RC - 1) begin
                        m_cyc[b] = 0;
                        if (m_row[b] == ROWS - 1) begin
                            m_row[b] = 0; m_busy[b] = 0; m_done[b] = 1;
                        end else m_row[b]++;
                    end else m_cyc[b]++;
                end else if (st_b[b]) begin
                    m_busy[b] = 1; m_cyc[b] = 0;
                end
            end
            m_cnt = tick ? 0 : m_cnt + 1;
        end
    end

    // Per-cycle comparison and busy-length tracking
    int busy_len[NB];
    int passes[NB];
    initial for (int b = 0; b < NB; b++) begin busy_len[b] = 0; passes[b] = 0; end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            for (int b = 0; b < NB; b++) begin
                int g;
                int exp_req;
                g = b / BPG;
                exp_req = (m_st[g] == 1 && m_idx[g] == b % BPG) ? 1 : 0;
                check(refresh_req[b] == exp_req[0], $sformatf("R2 R7 R8 req bank %0d", b),
                      int'(refresh_req[b]), exp_req);
                check(bank_busy[b] == m_busy[b][0], $sformatf("R3 busy bank %0d", b),
                      int'(bank_busy[b]), m_busy[b]);
                check(int'(row_count[b*RW +: RW]) == m_row[b], $sformatf("R5 R9 row bank %0d", b),
                      int'(row_count[b*RW +: RW]), m_row[b]);
                check(pass_done[b] == m_done[b][0], $sformatf("R6 done bank %0d", b),
                      int'(pass_done[b]), m_done[b]);
                if (bank_busy[b]) busy_len[b]++;
                if (pass_done[b]) begin
                    passes[b]++;
                    check(busy_len[b] == ROWS * RC, $sformatf("R5 busy length bank %0d", b),
                          busy_len[b], ROWS * RC);
                    busy_len[b] = 0;
                end
            end
            for (int g = 0; g < G; g++)
                check($countones(bank_busy[g*BPG +: BPG]) <= 1, $sformatf("R4 busy per group %0d", g),
                      $countones(bank_busy[g*BPG +: BPG]), 1);
        end
    end

    int wait_cnt[NB];

    task automatic run(input int m, input int n);
        mode = m;
        repeat (n) begin
            @(negedge clk);
            for (int b = 0; b < NB; b++) begin
                wait_cnt[b] = refresh_req[b] ? wait_cnt[b] + 1 : 0;
                case (mode)
                    0: refresh_ack[b] = refresh_req[b];
                    1: refresh_ack[b] = refresh_req[b] && (wait_cnt[b] > 1 + (b * 3) % 7);
                    2: refresh_ack[b] = 1'b1;
                    default: refresh_ack[b] = 1'b0;
                endcase
            end
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) wait_cnt[b] = 0;
        repeat (3) @(negedge clk);
        check(bank_busy == '0, "R1 busy in reset", int'(bank_busy), 0);
        check(row_count == '0, "R1 rows in reset", int'(row_count), 0);
        check(refresh_req == '0, "R1 req in reset", int'(refresh_req), 0);
        check(pass_done == '0, "R1 done in reset", int'(pass_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bank_busy == '0 && pass_done == '0 && row_count == '0, "R1 after release",
              int'(bank_busy), 0);
        cmp_on = 1'b1;
        run(0, 800);   // prompt acknowledge
        run(1, 800);   // delayed acknowledge per bank
        run(2, 600);   // acknowledge on every bank
        run(3, 220);   // stalled: boundaries accumulate
        run(0, 800);
        for (int b = 0; b < NB; b++)
            check(passes[b] > 10, $sformatf("R6 R8 passes bank %0d", b), passes[b], 11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule